// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block holds the configuration that steers an image sensor's readout: the output window size and origin, the line period, the vertical blanking length, the exposure length in lines and in clocks, and the two flip bits. Every setting exists twice. Host writes arriving on a simple register-write port only change a staging copy. The active copy, which feeds the readout timing logic, is reloaded from the staging copy when the host commands it through a dedicated update-control register. Host reads of a setting return its staged value.

Two commit modes are offered. An immediate commit loads the active copy on the next clock edge and raises a one-cycle request to the timing logic to abandon the frame in progress and start a fresh one. A deferred commit arms a pending flag, and the active copy is reloaded on the first frame-start pulse that follows, so a new setting never takes effect in the middle of a frame. A staged write that lands in the same cycle as a commit is part of that commit.

Top module: `shadow_frame_bank`

## Requirements
- R1: After a synchronous reset both copies hold the defaults: width 0x780, height 0x438, line time 0x12C4, blanking 0x0024, exposure in lines 0x0032, all other settings 0; the restart request is low and no update is pending.
- R2: A write to a staged address changes no active output until a commit takes place.
- R3: Staged byte k (k = 0..16) sits at address 0x0040+k; a read returns the staged (not active) value on rd_data one cycle after rd_addr is presented, and any unmapped address reads 0x00.
- R4: Writing the update-control register at address 0x001D with bit 0 set copies the staged set to the active set at that clock edge, pulses frame_restart high for exactly one cycle and clears any pending update.
- R5: Writing 0x001D with bit 0 clear and bit 1 set arms a pending update without changing the active set and without a restart request.
- R6: A frame_start pulse while an update is pending loads the active set at that edge and clears the pending flag; a frame_start with nothing pending changes nothing.
- R7: An immediate command after a deferred one takes priority: the later frame_start performs no second load.
- R8: Reading 0x001D returns 0x02 while an update is pending and 0x00 otherwise; writing 0x00 to it has no effect.
- R9: A staged write in the same cycle as a frame_start commit is included in the values that become active.
- R10: Byte layout (low byte at even index, high byte at the next): 0-1 width, 2-3 height, 4-5 horizontal start, 6-7 vertical start, 8-9 line time, 10-11 blanking, 12-13 exposure in lines, 14-15 exposure in clocks, 16 flip bits (bit 1 horizontal, bit 0 vertical); the high bytes of the four 11-bit fields keep bits [2:0] only and byte 16 keeps bits [1:0] only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 16 | Host read address |
| rd_data | output | 8 | Registered read data |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| frame_restart | output | 1 | One-cycle request to abandon the frame and restart |
| h_size | output | 11 | Active output width |
| v_size | output | 11 | Active output height |
| h_start | output | 11 | Active horizontal start |
| v_start | output | 11 | Active vertical start |
| line_time | output | 16 | Active line period in clocks |
| v_blank | output | 16 | Active vertical blanking in lines |
| exp_rows | output | 16 | Active exposure in lines |
| exp_clks | output | 16 | Active exposure in clocks |
| mirror | output | 2 | Active flip bits, bit 1 horizontal, bit 0 vertical |

## Verification
Every staged byte is swept with distinct values so that a crossed byte lane or a wrong mask shows up both in the read-back and in the active field it lands in, and the flip byte is swept through all 256 write values with an immediate commit each time. Each commit path is tried in isolation and in the orderings that separate them: deferred then frame start, frame start with nothing armed, deferred overtaken by immediate, and a staged write coinciding with the consuming frame start. Between a staged write and its commit the active outputs are compared after every step, which separates a staging copy from a write-through register.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int BYTE_W = 8;
  localparam int NBYTE  = 17;
  localparam int SIZE_W = 11;
  localparam int TIME_W = 16;
  localparam int MIR_W  = 2;
  localparam int FLAT_W = NBYTE * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic [SIZE_W-1:0] h_size;
    logic [SIZE_W-1:0] v_size;
    logic [SIZE_W-1:0] h_start;
    logic [SIZE_W-1:0] v_start;
    logic [TIME_W-1:0] line_time;
    logic [TIME_W-1:0] v_blank;
    logic [TIME_W-1:0] exp_rows;
    logic [TIME_W-1:0] exp_clks;
    logic [MIR_W-1:0]  mirror;
  } cfg_t;

  // Storable bits per staged byte.
  function automatic byte_t byte_mask(input int idx);
    if (idx < 8 && (idx % 2) == 1) return byte_t'((1 << (SIZE_W - BYTE_W)) - 1);
    else if (idx == NBYTE - 1)     return byte_t'((1 << MIR_W) - 1);
    else                           return '1;
  endfunction

  function automatic byte_t byte_default(input int idx);
    case (idx)
      0:       return 8'h80;
      1:       return 8'h07;
      2:       return 8'h38;
      3:       return 8'h04;
      8:       return 8'hC4;
      9:       return 8'h12;
      10:      return 8'h24;
      12:      return 8'h32;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [FLAT_W-1:0] default_flat();
    logic [FLAT_W-1:0] f;
    for (int i = 0; i < NBYTE; i++) f[i*BYTE_W +: BYTE_W] = byte_default(i);
    return f;
  endfunction

  function automatic cfg_t unpack_cfg(input logic [FLAT_W-1:0] f);
    cfg_t c;
    c.h_size    = SIZE_W'({f[1*BYTE_W +: BYTE_W],  f[0*BYTE_W +: BYTE_W]});
    c.v_size    = SIZE_W'({f[3*BYTE_W +: BYTE_W],  f[2*BYTE_W +: BYTE_W]});
    c.h_start   = SIZE_W'({f[5*BYTE_W +: BYTE_W],  f[4*BYTE_W +: BYTE_W]});
    c.v_start   = SIZE_W'({f[7*BYTE_W +: BYTE_W],  f[6*BYTE_W +: BYTE_W]});
    c.line_time = {f[9*BYTE_W +: BYTE_W],  f[8*BYTE_W +: BYTE_W]};
    c.v_blank   = {f[11*BYTE_W +: BYTE_W], f[10*BYTE_W +: BYTE_W]};
    c.exp_rows  = {f[13*BYTE_W +: BYTE_W], f[12*BYTE_W +: BYTE_W]};
    c.exp_clks  = {f[15*BYTE_W +: BYTE_W], f[14*BYTE_W +: BYTE_W]};
    c.mirror    = MIR_W'(f[16*BYTE_W +: BYTE_W]);
    return c;
  endfunction
endpackage

// File: rtl/shadow_stage_bank.sv
module shadow_stage_bank
  import shadow_bank_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STAGE_BASE = 16'h0040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_byte,
  output logic              rd_hit,
  output logic [FLAT_W-1:0] flat_next
);
  logic [FLAT_W-1:0] flat_q;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    logic  hit;
    byte_t q;
    assign hit = wr_en && (wr_addr == ADDR_W'(STAGE_BASE + i));
    // Next value already holds this cycle's write, so a commit sees it.
    assign flat_next[i*BYTE_W +: BYTE_W] = hit ? (wr_data & byte_mask(i)) : q;
    always_ff @(posedge clk) begin
      if (rst) q <= byte_default(i);
      else     q <= flat_next[i*BYTE_W +: BYTE_W];
    end
    assign flat_q[i*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_byte = '0;
    rd_hit  = 1'b0;
    for (int i = 0; i < NBYTE; i++) begin
      if (rd_addr == ADDR_W'(STAGE_BASE + i)) begin
        rd_byte = flat_q[i*BYTE_W +: BYTE_W];
        rd_hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h001D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        cmd_bits,
  input  logic              frame_start,
  output logic              commit,
  output logic              pending,
  output logic              restart
);
  logic ctrl_hit, cmd_now, cmd_arm, pending_n;

  assign ctrl_hit = wr_en && (wr_addr == CTRL_ADDR);
  assign cmd_now  = ctrl_hit && cmd_bits[0];
  assign cmd_arm  = ctrl_hit && !cmd_bits[0] && cmd_bits[1];
  assign commit   = cmd_now || (pending && frame_start);

  always_comb begin
    pending_n = pending;
    if (cmd_now)                     pending_n = 1'b0;
    else if (cmd_arm)                pending_n = 1'b1;
    else if (pending && frame_start) pending_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      restart <= 1'b0;
    end else begin
      pending <= pending_n;
      restart <= cmd_now;
    end
  end

  assert_now_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_ADDR && cmd_bits[0]) |=> (restart && !pending));

  assert_arm_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_ADDR && cmd_bits == 2'b10) |=> (pending && !restart));

  assert_consume_R6: assert property (@(posedge clk) disable iff (rst)
    (pending && frame_start && !(wr_en && wr_addr == CTRL_ADDR && cmd_bits != 2'b00))
      |=> !pending);
endmodule

// File: rtl/shadow_active_set.sv
module shadow_active_set
  import shadow_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [FLAT_W-1:0] flat_next,
  output cfg_t              cfg
);
  always_ff @(posedge clk) begin
    if (rst)         cfg <= unpack_cfg(default_flat());
    else if (commit) cfg <= unpack_cfg(flat_next);
  end
endmodule

// File: rtl/shadow_frame_bank.sv
module shadow_frame_bank
  import shadow_bank_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h001D,
  parameter logic [ADDR_W-1:0] STAGE_BASE = 16'h0040
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                frame_start,
  output logic                frame_restart,
  output logic [SIZE_W-1:0]   h_size,
  output logic [SIZE_W-1:0]   v_size,
  output logic [SIZE_W-1:0]   h_start,
  output logic [SIZE_W-1:0]   v_start,
  output logic [TIME_W-1:0]   line_time,
  output logic [TIME_W-1:0]   v_blank,
  output logic [TIME_W-1:0]   exp_rows,
  output logic [TIME_W-1:0]   exp_clks,
  output logic [MIR_W-1:0]    mirror
);
  logic [FLAT_W-1:0] flat_next;
  byte_t             rd_byte;
  logic              rd_hit, commit, pending;
  cfg_t              cfg;

  shadow_stage_bank #(.ADDR_W(ADDR_W), .STAGE_BASE(STAGE_BASE)) u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_hit(rd_hit), .flat_next(flat_next)
  );

  shadow_commit_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .cmd_bits(wr_data[1:0]),
    .frame_start(frame_start), .commit(commit), .pending(pending), .restart(frame_restart)
  );

  shadow_active_set u_active (
    .clk(clk), .rst(rst), .commit(commit), .flat_next(flat_next), .cfg(cfg)
  );

  always_ff @(posedge clk) begin
    if (rst)                      rd_data <= '0;
    else if (rd_addr == CTRL_ADDR) rd_data <= {6'b0, pending, 1'b0};
    else if (rd_hit)              rd_data <= rd_byte;
    else                          rd_data <= '0;
  end

  assign h_size    = cfg.h_size;
  assign v_size    = cfg.v_size;
  assign h_start   = cfg.h_start;
  assign v_start   = cfg.v_start;
  assign line_time = cfg.line_time;
  assign v_blank   = cfg.v_blank;
  assign exp_rows  = cfg.exp_rows;
  assign exp_clks  = cfg.exp_clks;
  assign mirror    = cfg.mirror;

  // Active outputs move only after a control write or a frame start.
  assert_active_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_addr == CTRL_ADDR) && !frame_start) |=> $stable(cfg));
endmodule

// File: tb/test_shadow_frame_bank.sv
module test_shadow_frame_bank;
  localparam logic [15:0] CTRL = 16'h001D;
  localparam logic [15:0] BASE = 16'h0040;

  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 1'b0, frame_start = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        frame_restart;
  logic [10:0] h_size, v_size, h_start, v_start;
  logic [15:0] line_time, v_blank, exp_rows, exp_clks;
  logic [1:0]  mirror;

  int total = 0, bad = 0;
  logic [7:0] stg [17];
  logic [7:0] act [17];

  always #10 clk = ~clk;

  shadow_frame_bank i_shadow_frame_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
    .frame_restart(frame_restart), .h_size(h_size), .v_size(v_size),
    .h_start(h_start), .v_start(v_start), .line_time(line_time), .v_blank(v_blank),
    .exp_rows(exp_rows), .exp_clks(exp_clks), .mirror(mirror)
  );

  // R10 masks: high bytes of the four 11-bit fields keep 3 bits, flip byte keeps 2.
  function automatic logic [7:0] msk(input int k);
    if (k < 8 && k % 2 == 1) return 8'h07;
    if (k == 16) return 8'h03;
    return 8'hFF;
  endfunction

  function automatic logic [109:0] exp_vec();
    return {act[1][2:0], act[0], act[3][2:0], act[2], act[5][2:0], act[4],
            act[7][2:0], act[6], act[9], act[8], act[11], act[10],
            act[13], act[12], act[15], act[14], act[16][1:0]};
  endfunction

  function automatic logic [109:0] dut_vec();
    return {h_size, v_size, h_start, v_start, line_time, v_blank, exp_rows, exp_clks, mirror};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic chk_active(input string req);
    chk(dut_vec() == exp_vec(), req, 128'(dut_vec()), 128'(exp_vec()));
  endtask

  // Drive one cycle (called at a negedge), return at the next negedge.
  task automatic op(input bit w, input logic [15:0] a, input logic [7:0] d, input bit fs);
    wr_en = w; wr_addr = a; wr_data = d; frame_start = fs;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
  endtask

  task automatic stage_wr(input int k, input logic [7:0] d);
    op(1'b1, BASE + 16'(k), d, 1'b0);
    stg[k] = d & msk(k);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string req);
    rd_addr = a;
    @(negedge clk);
    chk(rd_data == e, req, 128'(rd_data), 128'(e));
  endtask

  task automatic take();
    for (int k = 0; k < 17; k++) act[k] = stg[k];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 17; k++) begin stg[k] = 8'h00; end
    stg[0] = 8'h80; stg[1] = 8'h07; stg[2] = 8'h38; stg[3] = 8'h04;
    stg[8] = 8'hC4; stg[9] = 8'h12; stg[10] = 8'h24; stg[12] = 8'h32;
    take();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_active("R1 active defaults");
    chk(frame_restart == 1'b0, "R1 restart low", 128'(frame_restart), 128'(0));
    rd_chk(CTRL, 8'h00, "R1/R8 nothing pending");
    for (int k = 0; k < 17; k++) rd_chk(BASE + 16'(k), stg[k], "R1/R3 staged default");

    // R2 / R10 sweep every staged byte, active must not move
    for (int k = 0; k < 17; k++) begin
      stage_wr(k, 8'((k * 37 + 5) ^ 8'hA5));
      chk_active("R2 staged write leaves active");
    end
    for (int k = 0; k < 17; k++) rd_chk(BASE + 16'(k), stg[k], "R3/R10 staged readback masked");
    rd_chk(16'h0011, 8'h00, "R3 unmapped low");
    rd_chk(BASE + 16'd17, 8'h00, "R3 unmapped past end");

    // R8 zero command is a no-op
    op(1'b1, CTRL, 8'h00, 1'b0);
    chk_active("R8 zero command no load");
    chk(frame_restart == 1'b0, "R8 zero command no restart", 128'(frame_restart), 128'(0));

    // R4 immediate commit
    op(1'b1, CTRL, 8'h01, 1'b0);
    take();
    chk(frame_restart == 1'b1, "R4 restart pulse", 128'(frame_restart), 128'(1));
    chk_active("R4 immediate load / R10 layout");
    @(negedge clk);
    chk(frame_restart == 1'b0, "R4 restart one cycle", 128'(frame_restart), 128'(0));

    // R5 deferred: arm then wait
    for (int k = 0; k < 17; k++) stage_wr(k, 8'((k * 91 + 17) ^ 8'h3C));
    op(1'b1, CTRL, 8'h02, 1'b0);
    chk(frame_restart == 1'b0, "R5 no restart on arm", 128'(frame_restart), 128'(0));
    chk_active("R5 armed, active unchanged");
    rd_chk(CTRL, 8'h02, "R8 pending reads 0x02");
    repeat (3) @(negedge clk);
    chk_active("R5 still unchanged before frame start");

    // R6 + R9 frame start consumes, same-cycle staged write included
    op(1'b1, BASE + 16'd16, 8'hFE, 1'b1);
    stg[16] = 8'hFE & msk(16);
    take();
    chk_active("R6/R9 frame start load with same-cycle write");
    chk(frame_restart == 1'b0, "R6 no restart on deferred load", 128'(frame_restart), 128'(0));
    rd_chk(CTRL, 8'h00, "R6/R8 pending cleared");

    // R6 frame start with nothing pending
    stage_wr(8, 8'h5A);
    op(1'b0, 16'h0000, 8'h00, 1'b1);
    chk_active("R6 idle frame start no load");

    // R7 immediate overtakes deferred
    stage_wr(14, 8'hC3);
    op(1'b1, CTRL, 8'h02, 1'b0);
    op(1'b1, CTRL, 8'h01, 1'b0);
    take();
    chk_active("R7 immediate after arm loads");
    rd_chk(CTRL, 8'h00, "R7 pending cleared by immediate");
    stage_wr(15, 8'h77);
    op(1'b0, 16'h0000, 8'h00, 1'b1);
    chk_active("R7 no second load at frame start");

    // R4 bit 0 wins over bit 1 (value 0x03)
    op(1'b1, CTRL, 8'h03, 1'b0);
    take();
    chk(frame_restart == 1'b1, "R4 value 0x03 restarts", 128'(frame_restart), 128'(1));
    chk_active("R4 value 0x03 immediate load");
    rd_chk(CTRL, 8'h00, "R4 value 0x03 leaves nothing pending");

    // R10 flip byte exhaustive through immediate commits
    for (int v = 0; v < 256; v++) begin
      stage_wr(16, 8'(v));
      op(1'b1, CTRL, 8'h01, 1'b0);
      take();
      chk(mirror == 2'(v), "R10 flip bits", 128'(mirror), 128'(v & 3));
    end
    chk_active("R10 all fields after flip sweep");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule